// File: doc/BRIEF.md
# Stack and Frame Pointer Address Unit

This unit produces data-memory addresses for two kinds of access used by a small processor core. The first is a soft stack that grows toward lower addresses. A push moves the pointer down one word and then writes at the new location. A pop reads at the current location and then moves the pointer back up. The second is a frame pointer. It is formed as the unsigned sum of a 16-bit base register and an 8-bit offset register. A frame access may step the offset by one in either direction. For reads the step happens after the address is formed, and for writes it happens before.

The core drives push, pop and frame requests for one cycle. The unit answers in the same cycle with a combinational address, and it updates its pointers at the next clock edge. A register port lets the core write and read the stack pointer, the base and the offset directly. The offset wraps within its own eight bits and never disturbs the base.

Top module: `stack_frame_addr_unit`

## Requirements
- R1: The stack pointer keeps only bits 9:0. A register read of it (select 0) returns bits 15:10 as zero, and a register write stores only bits 9:0 of the written data.
- R2: After reset the stack pointer reads 03F0h, the base (select 1) reads 0000h and the offset (select 2) reads 00h. Select 3 reads 0000h and ignores writes.
- R3: A push alone drives stackAddrValid high and stackAddr to (SP-1) mod 1024 in the same cycle. SP holds that value after the clock edge.
- R4: A pop alone drives stackAddrValid high and stackAddr to the current SP. SP holds (SP+1) mod 1024 after the clock edge.
- R5: The stack pointer wraps modulo 1024 with no error indication. A push at 000h addresses and leaves 3FFh, and a pop at 3FFh leaves 000h.
- R6: A push and a pop requested in the same cycle are both rejected. stackAddrValid stays low, stackAddr reads 0000h and SP is unchanged.
- R7: frameAddr equals (base + zero-extended offset) mod 65536.
- R8: A frame read (frameWrite=0) uses the current offset for frameAddr. The offset then steps by +1 for modifier 1, by -1 for modifier 2, and not at all for modifiers 0 and 3.
- R9: A frame write (frameWrite=1) with modifier 1 or 2 steps the offset first and uses the stepped value for frameAddr. The stepped value is stored.
- R10: Offset steps wrap modulo 256, and a frame access never changes the base.
- R11: When a register write and an operation target the same pointer in one cycle, the written value is stored. The address output still follows the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 SP, 1 base, 2 offset, 3 none |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data of the selected register |
| pushReq | input | 1 | Push request |
| popReq | input | 1 | Pop request |
| stackAddr | output | 16 | Stack access address |
| stackAddrValid | output | 1 | Exactly one stack request accepted |
| frameReq | input | 1 | Frame access request |
| frameWrite | input | 1 | 1 for a frame write, 0 for a frame read |
| frameMod | input | 2 | Offset modifier: 0 none, 1 increment, 2 decrement, 3 none |
| frameAddr | output | 16 | Frame pointer address |

## Verification
The bench sweeps every stack pointer value through both a push and a pop, with the upper data bits set on each write. A unit that decremented after the push, incremented before the pop, or kept bits 15:10 would show a wrong address or readback at some value. The wrap points at 000h and 3FFh are covered by this sweep. Every offset is run through both directions and all four modifiers on two bases, one of them near the top of the address space. A unit that swapped pre- and post-stepping, let the offset carry into the base, or truncated the 16-bit sum would miss there. Push and pop together, and register writes that collide with pointer steps, are also driven, where a wrong priority shows up as a moved pointer.

// File: rtl/sfau_pkg.sv
package sfau_pkg;

  typedef enum logic [1:0] {
    SEL_SP   = 2'd0,
    SEL_BP   = 2'd1,
    SEL_OFFS = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    MOD_NONE = 2'd0,
    MOD_INC  = 2'd1,
    MOD_DEC  = 2'd2,
    MOD_RSVD = 2'd3
  } frameMod_e;

  // strobes from control to datapath
  typedef struct packed {
    logic spWr;       // register port writes SP
    logic bpWr;       // register port writes base
    logic offsWr;     // register port writes offset
    logic stackValid; // exactly one stack request
    logic pushSel;    // the accepted request is a push
    logic spDec;      // SP steps down this edge
    logic spInc;      // SP steps up this edge
    logic offsUp;     // requested offset step +1
    logic offsDn;     // requested offset step -1
    logic offsPre;    // address uses stepped offset
    logic offsUpd;    // stepped offset is stored
  } dpCtl_t;

endpackage

// File: rtl/sfau_ctrl.sv
module sfau_ctrl
  import sfau_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic [1:0] regSel,
  input  logic       pushReq,
  input  logic       popReq,
  input  logic       frameReq,
  input  logic       frameWrite,
  input  logic [1:0] frameMod,
  output dpCtl_t     ctl
);

  regSel_e   selE;
  frameMod_e modE;
  logic      oneStack;
  logic      stepReq;

  assign selE     = regSel_e'(regSel);
  assign modE     = frameMod_e'(frameMod);
  assign oneStack = pushReq ^ popReq;
  assign stepReq  = frameReq && (modE == MOD_INC || modE == MOD_DEC);

  always_comb begin
    ctl            = '0;
    ctl.spWr       = regWrEn && (selE == SEL_SP);
    ctl.bpWr       = regWrEn && (selE == SEL_BP);
    ctl.offsWr     = regWrEn && (selE == SEL_OFFS);
    ctl.stackValid = oneStack;
    ctl.pushSel    = oneStack && pushReq;
    // register write wins over a pointer step (R11)
    ctl.spDec      = oneStack && pushReq && !ctl.spWr;
    ctl.spInc      = oneStack && popReq  && !ctl.spWr;
    ctl.offsUp     = frameReq && (modE == MOD_INC);
    ctl.offsDn     = frameReq && (modE == MOD_DEC);
    ctl.offsPre    = frameReq && frameWrite;
    ctl.offsUpd    = stepReq && !ctl.offsWr;
  end

  p_no_double_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && popReq) |-> !(ctl.spDec || ctl.spInc || ctl.stackValid));

  p_one_dir_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.offsUp, ctl.offsDn}));

endmodule

// File: rtl/sfau_dp.sv
module sfau_dp
  import sfau_pkg::*;
#(
  parameter int            DATA_W = 16,
  parameter int            SP_W   = 10,
  parameter int            OFFS_W = 8,
  parameter logic [DATA_W-1:0] SP_RST = 16'h03F0
)(
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [1:0]        rdSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] stackAddr,
  output logic              stackAddrValid,
  output logic [DATA_W-1:0] frameAddr
);

  localparam logic [SP_W-1:0] SP_INIT = SP_RST[SP_W-1:0];

  logic [SP_W-1:0]   spQ;
  logic [DATA_W-1:0] bpQ;
  logic [OFFS_W-1:0] offsQ;

  logic [SP_W-1:0]   spMinus;
  logic [SP_W-1:0]   spPlus;
  logic [OFFS_W-1:0] offsStep;
  logic [OFFS_W-1:0] offsUse;

  assign spMinus = spQ - 1'b1;
  assign spPlus  = spQ + 1'b1;

  always_comb begin
    if (ctl.offsUp)      offsStep = offsQ + 1'b1;
    else if (ctl.offsDn) offsStep = offsQ - 1'b1;
    else                 offsStep = offsQ;
  end

  assign offsUse        = ctl.offsPre ? offsStep : offsQ;
  assign frameAddr      = bpQ + DATA_W'(offsUse);
  assign stackAddrValid = ctl.stackValid;
  assign stackAddr      = !ctl.stackValid ? '0 :
                          (ctl.pushSel ? DATA_W'(spMinus) : DATA_W'(spQ));

  always_comb begin
    unique case (regSel_e'(rdSel))
      SEL_SP:   rdData = DATA_W'(spQ);
      SEL_BP:   rdData = bpQ;
      SEL_OFFS: rdData = DATA_W'(offsQ);
      default:  rdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spQ <= SP_INIT;
    end else if (ctl.spWr) begin
      spQ <= wrData[SP_W-1:0];
    end else if (ctl.spDec) begin
      spQ <= spMinus;
    end else if (ctl.spInc) begin
      spQ <= spPlus;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          bpQ <= '0;
    else if (ctl.bpWr)  bpQ <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            offsQ <= '0;
    else if (ctl.offsWr)  offsQ <= wrData[OFFS_W-1:0];
    else if (ctl.offsUpd) offsQ <= offsStep;
  end

  p_sp_hi_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    (regSel_e'(rdSel) == SEL_SP) |-> (rdData[DATA_W-1:SP_W] == '0));

  p_push_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.spDec |=> (spQ == SP_W'($past(spQ) - 1'b1)));

  p_pop_inc_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.spInc |=> (spQ == SP_W'($past(spQ) + 1'b1)));

  p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.stackValid && !ctl.spWr) |=> $stable(spQ));

  p_base_kept_r10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.bpWr |=> $stable(bpQ));

endmodule

// File: rtl/stack_frame_addr_unit.sv
module stack_frame_addr_unit
  import sfau_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SP_W   = 10,
  parameter int OFFS_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              pushReq,
  input  logic              popReq,
  output logic [DATA_W-1:0] stackAddr,
  output logic              stackAddrValid,
  input  logic              frameReq,
  input  logic              frameWrite,
  input  logic [1:0]        frameMod,
  output logic [DATA_W-1:0] frameAddr
);

  dpCtl_t ctl;

  sfau_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .regWrEn    (regWrEn),
    .regSel     (regSel),
    .pushReq    (pushReq),
    .popReq     (popReq),
    .frameReq   (frameReq),
    .frameWrite (frameWrite),
    .frameMod   (frameMod),
    .ctl        (ctl)
  );

  sfau_dp #(
    .DATA_W (DATA_W),
    .SP_W   (SP_W),
    .OFFS_W (OFFS_W)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .ctl            (ctl),
    .rdSel          (regSel),
    .wrData         (regWrData),
    .rdData         (regRdData),
    .stackAddr      (stackAddr),
    .stackAddrValid (stackAddrValid),
    .frameAddr      (frameAddr)
  );

endmodule

// File: tb/stack_frame_addr_unit_bench.sv
module stack_frame_addr_unit_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWrData = 16'h0;
  logic [15:0] regRdData;
  logic        pushReq = 1'b0;
  logic        popReq = 1'b0;
  logic [15:0] stackAddr;
  logic        stackAddrValid;
  logic        frameReq = 1'b0;
  logic        frameWrite = 1'b0;
  logic [1:0]  frameMod = 2'd0;
  logic [15:0] frameAddr;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  stack_frame_addr_unit u_stack_frame_addr_unit (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .pushReq(pushReq),
    .popReq(popReq), .stackAddr(stackAddr), .stackAddrValid(stackAddrValid),
    .frameReq(frameReq), .frameWrite(frameWrite), .frameMod(frameMod),
    .frameAddr(frameAddr)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // move to 2 time units after the next rising edge
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [15:0] val);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [1:0] sel, input logic [15:0] exp);
    regSel = sel;
    #1;
    chk(req, regRdData, exp);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 2 + 2);
    rstN = 1'b1;
    step();
    // R2 reset values
    rdChk("R2 sp", 2'd0, 16'h03F0);
    rdChk("R2 bp", 2'd1, 16'h0000);
    rdChk("R2 offs", 2'd2, 16'h0000);
    rdChk("R2 sel3", 2'd3, 16'h0000);
    wrReg(2'd3, 16'hBEEF);
    rdChk("R2 sel3 write ignored", 2'd3, 16'h0000);
    rdChk("R2 sp after sel3 write", 2'd0, 16'h03F0);

    // R1 R3 R4 R5 sweep over every SP value
    for (int v = 0; v < 1024; v++) begin
      logic [9:0] vv;
      vv = 10'(v);
      wrReg(2'd0, {6'h3F, vv});
      rdChk("R1 readback", 2'd0, {6'h00, vv});
      pushReq = 1'b1;
      #1;
      chk("R3 push valid", {15'h0, stackAddrValid}, 16'h1);
      chk("R3 R5 push addr", stackAddr, {6'h00, 10'(vv - 10'd1)});
      step();
      pushReq = 1'b0;
      rdChk("R3 R5 sp after push", 2'd0, {6'h00, 10'(vv - 10'd1)});
      wrReg(2'd0, {6'h00, vv});
      popReq = 1'b1;
      #1;
      chk("R4 pop valid", {15'h0, stackAddrValid}, 16'h1);
      chk("R4 pop addr", stackAddr, {6'h00, vv});
      step();
      popReq = 1'b0;
      rdChk("R4 R5 sp after pop", 2'd0, {6'h00, 10'(vv + 10'd1)});
    end

    // R6 simultaneous push and pop
    for (int v = 0; v < 1024; v += 255) begin
      wrReg(2'd0, 16'(v));
      pushReq = 1'b1; popReq = 1'b1;
      #1;
      chk("R6 valid low", {15'h0, stackAddrValid}, 16'h0);
      chk("R6 addr zero", stackAddr, 16'h0000);
      step();
      pushReq = 1'b0; popReq = 1'b0;
      rdChk("R6 sp held", 2'd0, 16'(v));
    end

    // R11 register write collides with a push and with a frame step
    wrReg(2'd0, 16'h0200);
    pushReq = 1'b1; regWrEn = 1'b1; regSel = 2'd0; regWrData = 16'h0123;
    #1;
    chk("R11 push addr", stackAddr, 16'h01FF);
    step();
    pushReq = 1'b0; regWrEn = 1'b0;
    rdChk("R11 sp written", 2'd0, 16'h0123);
    wrReg(2'd2, 16'h0010);
    frameReq = 1'b1; frameWrite = 1'b1; frameMod = 2'd1;
    regWrEn = 1'b1; regSel = 2'd2; regWrData = 16'h0077;
    #1;
    chk("R11 frame addr", frameAddr, 16'h0011);
    step();
    frameReq = 1'b0; regWrEn = 1'b0;
    rdChk("R11 offs written", 2'd2, 16'h0077);

    // R7 R8 R9 R10 sweep over offsets, directions and modifiers
    for (int b = 0; b < 2; b++) begin
      logic [15:0] base;
      base = (b == 0) ? 16'h1234 : 16'hFFC0;
      wrReg(2'd1, base);
      for (int o = 0; o < 256; o++) begin
        for (int m = 0; m < 8; m++) begin
          logic [7:0]  oo, stepped;
          logic [15:0] expAddr;
          logic        isWr;
          logic [1:0]  md;
          oo = 8'(o);
          isWr = m[2];
          md = 2'(m);
          stepped = (md == 2'd1) ? oo + 8'd1 : (md == 2'd2) ? oo - 8'd1 : oo;
          expAddr = isWr ? base + {8'h00, stepped} : base + {8'h00, oo};
          wrReg(2'd2, {8'hA5, oo});
          frameReq = 1'b1; frameWrite = isWr; frameMod = md;
          #1;
          chk(isWr ? "R9 R7 frame write addr" : "R8 R7 frame read addr",
              frameAddr, expAddr);
          step();
          frameReq = 1'b0;
          rdChk(isWr ? "R9 R10 offs after write" : "R8 R10 offs after read",
                2'd2, {8'h00, stepped});
          rdChk("R10 base kept", 2'd1, base);
        end
      end
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule